// File: doc/BRIEF.md
# Interprocessor Interrupt Command Register

This block is the command register pair through which a local processor sends an interrupt message to other processors. Software programs it over a 32-bit register port. One word, the destination word, holds the 8-bit target identifier. The other word, the command word, holds the vector, delivery mode, level, trigger mode and destination shorthand. Writing the command word is the act that sends: the block takes a snapshot of both words and offers the message on an outbound valid/ready port.

While the message waits for the target, a busy bit in the command word reads 1. Software polls this bit until it clears. A command write that arrives while a message is still pending is dropped, and a sticky error flag records the drop. Register accesses are one whole 32-bit word at an offset aligned to 16 bytes. An offset with any of its low four bits set decodes to nothing.

The outbound port follows valid/ready rules. `msg_valid` rises on the clock after an accepted command write. Once raised, it stays high, with every payload field stable, until the clock edge at which `msg_ready` is sampled high. The consumer may hold `msg_ready` high ahead of time, in which case the handshake completes on the first cycle of `msg_valid`. The block cannot be back-pressured into losing a message, because it never launches a second one while the first is pending.

Top module: `ipi_cmd_reg`

## Requirements
- R1: After reset, both words read 0, `msg_valid` is 0 and `err_busy_write` is 0.
- R2: Writing the destination word (offset `HIGH_OFS`) stores bits 31:24 only. Its other bits read back as 0. The write launches no message.
- R3: A command-word write (offset `LOW_OFS`) while idle raises `msg_valid` on the next cycle. The payload carries the vector from bits 7:0, the mode from bits 10:8, the level from bit 14, the trigger mode from bit 15 and the shorthand from bits 19:18, with `msg_dest` taken from the stored destination word.
- R4: Command-word bit 12 (busy) reads 1 from the cycle after launch until the handshake. It reads 0 starting the cycle after the edge at which `msg_valid` and `msg_ready` are both high.
- R5: While `msg_valid` is high and `msg_ready` is low, `msg_valid` stays high and all payload outputs hold their values.
- R6: When the shorthand field is nonzero (3 = all excluding self), `msg_dest` is presented as 0 whatever the destination word holds.
- R7: A command-word write while busy is ignored. The stored fields and the pending message do not change. `err_busy_write` goes to 1 and stays 1 until reset.
- R8: An access at an offset that is not 16-byte aligned, or that is not one of the two mapped offsets, writes nothing and reads 0.
- R9: A destination-word write while busy updates the readable destination word but not the `msg_dest` of the pending message.
- R10: Command-word readback places vector[7:0], mode[10:8], busy[12], level[14], trigger[15] and shorthand[19:18]. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Write strobe for the register port |
| cfg_addr | input | ADDR_W | Byte offset of the access |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for `cfg_addr` (combinational) |
| msg_valid | output | 1 | Outbound message is pending |
| msg_ready | input | 1 | Target accepts the message |
| msg_dest | output | 8 | Destination identifier (0 when a shorthand is used) |
| msg_vector | output | 8 | Interrupt vector |
| msg_mode | output | 3 | Delivery mode |
| msg_level | output | 1 | Level-assert bit |
| msg_trigger | output | 1 | Trigger mode bit |
| msg_shorthand | output | 2 | Destination shorthand |
| err_busy_write | output | 1 | Sticky flag: a command write was dropped while busy |

## Verification
The bench holds `msg_ready` low across several cycles. A design that drops valid early, or lets the payload drift, fails there. It then rewrites the destination word during that window, which exposes a design that feeds `msg_dest` live from the register instead of from the launch snapshot. A second command write during the pending window must leave the readback and the pending message untouched and must set the error flag. A design that overwrites the fields, or relaunches, fails there. Further checks cover an all-ones command write, which catches stray or misplaced readback bits, and accesses at offsets off by 4 bytes, which a design that decodes only the upper address bits would wrongly accept.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  localparam int unsigned DW = 32;

  // Command word field positions (software-visible layout)
  localparam int unsigned VEC_LSB   = 0;
  localparam int unsigned MODE_LSB  = 8;
  localparam int unsigned BUSY_BIT  = 12;
  localparam int unsigned LEVEL_BIT = 14;
  localparam int unsigned TRIG_BIT  = 15;
  localparam int unsigned SH_LSB    = 18;
  // Destination word field position
  localparam int unsigned DEST_LSB  = 24;

  typedef enum logic [1:0] {
    SH_NONE     = 2'd0,
    SH_SELF     = 2'd1,
    SH_ALL_INCL = 2'd2,
    SH_ALL_EXCL = 2'd3
  } shorthand_e;

  typedef struct packed {
    logic [7:0] vector;
    logic [2:0] mode;
    logic       level;
    logic       trigger;
    logic [1:0] shorthand;
  } cmd_fields_t;

  typedef struct packed {
    logic [7:0]  dest;
    cmd_fields_t cmd;
  } ipi_msg_t;

  function automatic cmd_fields_t unpack_cmd(input logic [DW-1:0] w);
    cmd_fields_t f;
    f.vector    = w[VEC_LSB +: 8];
    f.mode      = w[MODE_LSB +: 3];
    f.level     = w[LEVEL_BIT];
    f.trigger   = w[TRIG_BIT];
    f.shorthand = w[SH_LSB +: 2];
    return f;
  endfunction

  function automatic logic [DW-1:0] pack_cmd(input cmd_fields_t f, input logic busy);
    logic [DW-1:0] w;
    w = '0;
    w[VEC_LSB +: 8]  = f.vector;
    w[MODE_LSB +: 3] = f.mode;
    w[BUSY_BIT]      = busy;
    w[LEVEL_BIT]     = f.level;
    w[TRIG_BIT]      = f.trigger;
    w[SH_LSB +: 2]   = f.shorthand;
    return w;
  endfunction
endpackage

// File: rtl/ipi_addr_decode.sv
module ipi_addr_decode #(
  parameter int unsigned ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] LOW_OFS  = 12'h300,
  parameter logic [ADDR_W-1:0] HIGH_OFS = 12'h310
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit_low,
  output logic              hit_high
);
  localparam int unsigned ALIGN_BITS = 4;

  logic aligned;

  always_comb begin
    aligned  = (addr[ALIGN_BITS-1:0] == '0);
    hit_low  = aligned && (addr == LOW_OFS);
    hit_high = aligned && (addr == HIGH_OFS);
  end
endmodule

// File: rtl/ipi_launch.sv
module ipi_launch
  import ipi_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_wr,
  input  cmd_fields_t cmd_in,
  input  logic [7:0]  dest_in,
  input  logic        msg_ready,
  output logic        busy,
  output logic        accept,
  output logic        err_sticky,
  output ipi_msg_t    msg
);
  logic     busy_q;
  logic     err_q;
  ipi_msg_t msg_q;
  ipi_msg_t snap;

  always_comb begin
    accept     = cmd_wr && !busy_q;
    snap.cmd   = cmd_in;
    snap.dest  = (cmd_in.shorthand == SH_NONE) ? dest_in : 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      msg_q  <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      msg_q  <= snap;
    end else if (busy_q && msg_ready) begin
      busy_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      err_q <= 1'b0;
    else if (cmd_wr && busy_q)
      err_q <= 1'b1;
  end

  assign busy       = busy_q;
  assign err_sticky = err_q;
  assign msg        = msg_q;
endmodule

// File: rtl/ipi_regs.sv
module ipi_regs
  import ipi_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dest_wr,
  input  logic          cmd_load,
  input  logic [DW-1:0] wdata,
  output logic [7:0]    dest_q,
  output cmd_fields_t   cmd_q
);
  logic [7:0]  dest_r;
  cmd_fields_t cmd_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dest_r <= '0;
      cmd_r  <= '0;
    end else begin
      if (dest_wr)
        dest_r <= wdata[DEST_LSB +: 8];
      if (cmd_load)
        cmd_r <= unpack_cmd(wdata);
    end
  end

  assign dest_q = dest_r;
  assign cmd_q  = cmd_r;
endmodule

// File: rtl/ipi_cmd_reg.sv
module ipi_cmd_reg
  import ipi_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] LOW_OFS  = 12'h300,
  parameter logic [ADDR_W-1:0] HIGH_OFS = 12'h310
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  output logic              msg_valid,
  input  logic              msg_ready,
  output logic [7:0]        msg_dest,
  output logic [7:0]        msg_vector,
  output logic [2:0]        msg_mode,
  output logic              msg_level,
  output logic              msg_trigger,
  output logic [1:0]        msg_shorthand,
  output logic              err_busy_write
);
  logic        hit_low, hit_high;
  logic        busy, accept;
  logic [7:0]  dest_q;
  cmd_fields_t cmd_q;
  ipi_msg_t    msg;

  ipi_addr_decode #(
    .ADDR_W  (ADDR_W),
    .LOW_OFS (LOW_OFS),
    .HIGH_OFS(HIGH_OFS)
  ) u_dec (
    .addr    (cfg_addr),
    .hit_low (hit_low),
    .hit_high(hit_high)
  );

  ipi_launch u_launch (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_wr    (cfg_wr && hit_low),
    .cmd_in    (unpack_cmd(cfg_wdata)),
    .dest_in   (dest_q),
    .msg_ready (msg_ready),
    .busy      (busy),
    .accept    (accept),
    .err_sticky(err_busy_write),
    .msg       (msg)
  );

  ipi_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .dest_wr (cfg_wr && hit_high),
    .cmd_load(accept),
    .wdata   (cfg_wdata),
    .dest_q  (dest_q),
    .cmd_q   (cmd_q)
  );

  always_comb begin
    cfg_rdata = '0;
    if (hit_low)
      cfg_rdata = pack_cmd(cmd_q, busy);
    else if (hit_high)
      cfg_rdata[DEST_LSB +: 8] = dest_q;
  end

  assign msg_valid     = busy;
  assign msg_dest      = msg.dest;
  assign msg_vector    = msg.cmd.vector;
  assign msg_mode      = msg.cmd.mode;
  assign msg_level     = msg.cmd.level;
  assign msg_trigger   = msg.cmd.trigger;
  assign msg_shorthand = msg.cmd.shorthand;
endmodule

// File: rtl/ipi_cmd_reg_chk.sv
module ipi_cmd_reg_chk #(
  parameter int unsigned ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] LOW_OFS  = 12'h300,
  parameter logic [ADDR_W-1:0] HIGH_OFS = 12'h310
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_wr,
  input logic [ADDR_W-1:0] cfg_addr,
  input logic [31:0]       cfg_rdata,
  input logic              msg_valid,
  input logic              msg_ready,
  input logic [7:0]        msg_dest,
  input logic [7:0]        msg_vector,
  input logic [2:0]        msg_mode,
  input logic              msg_level,
  input logic              msg_trigger,
  input logic [1:0]        msg_shorthand,
  input logic              err_busy_write
);
  logic [22:0] payload;
  assign payload = {msg_dest, msg_vector, msg_mode, msg_level, msg_trigger, msg_shorthand};

  assert_launch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_addr == LOW_OFS && !msg_valid) |=> msg_valid);

  assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_ready) |=> !msg_valid);

  assert_busy_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr == LOW_OFS) |-> (cfg_rdata[12] == msg_valid));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(payload)));

  assert_shorthand_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_shorthand != 2'd0) |-> (msg_dest == 8'h00));

  assert_err_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_addr == LOW_OFS && msg_valid) |=> err_busy_write);

  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_busy_write |=> err_busy_write);

  assert_unmapped_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr != LOW_OFS && cfg_addr != HIGH_OFS) |-> (cfg_rdata == 32'h0));

  assert_dest_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr == HIGH_OFS) |-> (cfg_rdata[23:0] == 24'h0));
endmodule

bind ipi_cmd_reg ipi_cmd_reg_chk #(
  .ADDR_W  (ADDR_W),
  .LOW_OFS (LOW_OFS),
  .HIGH_OFS(HIGH_OFS)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_wr        (cfg_wr),
  .cfg_addr      (cfg_addr),
  .cfg_rdata     (cfg_rdata),
  .msg_valid     (msg_valid),
  .msg_ready     (msg_ready),
  .msg_dest      (msg_dest),
  .msg_vector    (msg_vector),
  .msg_mode      (msg_mode),
  .msg_level     (msg_level),
  .msg_trigger   (msg_trigger),
  .msg_shorthand (msg_shorthand),
  .err_busy_write(err_busy_write)
);

// File: tb/tb_ipi_cmd_reg.sv
`timescale 1ns/1ps
module tb_ipi_cmd_reg;
  localparam logic [11:0] LOW  = 12'h300;
  localparam logic [11:0] HIGH = 12'h310;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [11:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        msg_valid, msg_ready = 1'b0;
  logic [7:0]  msg_dest, msg_vector;
  logic [2:0]  msg_mode;
  logic        msg_level, msg_trigger;
  logic [1:0]  msg_shorthand;
  logic        err_busy_write;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ipi_cmd_reg dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .msg_valid(msg_valid),
    .msg_ready(msg_ready), .msg_dest(msg_dest), .msg_vector(msg_vector),
    .msg_mode(msg_mode), .msg_level(msg_level), .msg_trigger(msg_trigger),
    .msg_shorthand(msg_shorthand), .err_busy_write(err_busy_write)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_addr = '0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    cfg_addr = a;
    #1 d = cfg_rdata;
    cfg_addr = '0;
  endtask

  task automatic ack();
    @(negedge clk);
    msg_ready = 1'b1;
    @(negedge clk);
    msg_ready = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(LOW, d);  check("R1", "low word", d, 32'h0);
    rd(HIGH, d); check("R1", "high word", d, 32'h0);
    check("R1", "valid", {31'b0, msg_valid}, 32'h0);
    check("R1", "err", {31'b0, err_busy_write}, 32'h0);
  endtask

  task automatic t_dest_word();
    logic [31:0] d;
    wr(HIGH, 32'hA512_3456);
    rd(HIGH, d); check("R2", "dest readback", d, 32'hA500_0000);
    check("R2", "no launch", {31'b0, msg_valid}, 32'h0);
  endtask

  task automatic t_launch_hold_busy();
    logic [31:0] d;
    wr(LOW, 32'h0000_4620);
    check("R3", "valid", {31'b0, msg_valid}, 32'h1);
    check("R3", "dest", {24'b0, msg_dest}, 32'hA5);
    check("R3", "vector", {24'b0, msg_vector}, 32'h20);
    check("R3", "mode", {29'b0, msg_mode}, 32'h6);
    check("R3", "level", {31'b0, msg_level}, 32'h1);
    rd(LOW, d); check("R4", "busy readback", d, 32'h0000_5620);
    repeat (3) @(negedge clk);
    check("R5", "valid held", {31'b0, msg_valid}, 32'h1);
    check("R5", "vector held", {24'b0, msg_vector}, 32'h20);
    wr(HIGH, 32'h7700_0000);
    rd(HIGH, d); check("R9", "dest word updated", d, 32'h7700_0000);
    check("R9", "pending dest kept", {24'b0, msg_dest}, 32'hA5);
    wr(LOW, 32'h0000_0500);
    check("R7", "err set", {31'b0, err_busy_write}, 32'h1);
    rd(LOW, d); check("R7", "fields kept", d, 32'h0000_5620);
    check("R7", "pending mode kept", {29'b0, msg_mode}, 32'h6);
    ack();
    check("R4", "valid cleared", {31'b0, msg_valid}, 32'h0);
    rd(LOW, d); check("R4", "busy cleared", d, 32'h0000_4620);
  endtask

  task automatic t_shorthand();
    logic [31:0] d;
    @(negedge clk) msg_ready = 1'b1;
    wr(LOW, 32'h000C_4500);
    check("R6", "valid", {31'b0, msg_valid}, 32'h1);
    check("R6", "dest forced 0", {24'b0, msg_dest}, 32'h0);
    check("R6", "shorthand", {30'b0, msg_shorthand}, 32'h3);
    @(negedge clk) msg_ready = 1'b0;
    check("R4", "ready-early clear", {31'b0, msg_valid}, 32'h0);
    rd(LOW, d); check("R4", "busy 0", d, 32'h000C_4500);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    wr(LOW + 12'h4, 32'h0000_4123);
    check("R8", "no launch misaligned", {31'b0, msg_valid}, 32'h0);
    rd(LOW + 12'h4, d); check("R8", "misaligned read", d, 32'h0);
    wr(HIGH + 12'h8, 32'hFF00_0000);
    rd(HIGH, d); check("R8", "high untouched", d, 32'h7700_0000);
    rd(12'h200, d); check("R8", "unmapped read", d, 32'h0);
    rd(LOW, d); check("R8", "low untouched", d, 32'h000C_4500);
  endtask

  task automatic t_layout();
    logic [31:0] d;
    wr(LOW, 32'hFFFF_FFFF);
    rd(LOW, d); check("R10", "all-ones layout", d, 32'h000C_D7FF);
    check("R10", "trigger", {31'b0, msg_trigger}, 32'h1);
    check("R10", "dest with shorthand", {24'b0, msg_dest}, 32'h0);
    ack();
    rd(LOW, d); check("R10", "layout idle", d, 32'h000C_C7FF);
    wr(LOW, 32'h0000_8031);
    check("R3", "dest from word", {24'b0, msg_dest}, 32'h77);
    check("R10", "trigger only", {31'b0, msg_trigger}, 32'h1);
    ack();
    check("R7", "err still sticky", {31'b0, err_busy_write}, 32'h1);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_dest_word();
    t_launch_hold_busy();
    t_shorthand();
    t_unmapped();
    t_layout();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule